// File: doc/BRIEF.md
# IDE Channel Register Window

This block sits between a simple memory-mapped request bus and one IDE channel that carries two devices. It decodes a 4 KB address window in which every register takes a 16-byte slot. Data-port, task-file and control/alternate-status accesses are passed on to a plain drive-side register port. The block itself holds a 32-bit timing register and a 32-bit interrupt status register. The interrupt status register latches two interrupt sources, DMA and drive, and each source is also copied to its own output line.

Every register accepts only certain access widths. An access at any other width is dropped: a read returns all ones, and a write leaves every register and the drive side untouched. Software can clear only the top bit of the interrupt status register. It does so with a full-word write that has bit 31 set.

The bus handshake is single-cycle: the block is always ready, and read data arrives one cycle after the request. The drive command engine, the DMA engine and the physical bus timing are outside this block.

Top module: `ide_regwin`

## Requirements
- R1: The register index is the byte address shifted right by four. Address bits 3:0 have no effect on which register is selected.
- R2: The access size encoding is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for illegal. Reads of index 0 (data) are legal at sizes 0, 1 and 2. A 4-byte read returns 32 bits and a 2-byte read returns the low 16 bits, zero-extended. A 1-byte read issues a 2-byte drive read and returns its low 8 bits, zero-extended.
- R3: Writes to the data port are accepted only at sizes 1 and 2. The value forwarded to the drive is masked to the access width (little-endian, low bytes). A 1-byte data write has no effect.
- R4: Indices 1 to 7 are task-file registers, forwarded to drive register numbers 1 to 7 on 1-byte accesses only. Reads return the low byte, zero-extended.
- R5: Index 8 and index 0x16 both reach drive register 8, which is alternate status on read and device control on write. Only 1-byte accesses are legal there.
- R6: Index 0x20 is a 32-bit timing register. It is read and written only at 4 bytes, has no side effects and resets to zero.
- R7: Index 0x30 is the interrupt status register, readable at 4 bytes. Bit 31 tracks the DMA source and bit 30 tracks the drive source. Each bit is set when its source rises and cleared when its source falls. All other bits read zero, and the register resets to zero.
- R8: A 4-byte write to index 0x30 with bit 31 set clears bit 31 and leaves bit 30 alone. A write with bit 31 clear, or a write at any other size, changes nothing.
- R9: The DMA and drive interrupt outputs equal the respective inputs delayed by one clock, and are zero in reset.
- R10: A read of an unmapped index, or a read at an illegal size (including size 3), returns 0xFFFFFFFF. An illegal write changes no register, internal or on the drive side.
- R11: Request ready is always high. Every read request produces a response one cycle later, and a write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_ready | output | 1 | Always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_size | input | 2 | Access size code (0:1B, 1:2B, 2:4B, 3:illegal) |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_valid | output | 1 | Read response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read response data |
| drv_rd | output | 1 | Drive-side register read strobe |
| drv_wr | output | 1 | Drive-side register write strobe |
| drv_reg | output | 4 | Drive register number (0 data, 1-7 task file, 8 control/alt status) |
| drv_size | output | 2 | Drive-side access size code |
| drv_wdata | output | 32 | Drive-side write data, masked to width |
| drv_rdata | input | 32 | Drive-side read data, valid in the same cycle as drv_rd |
| irq_dma_i | input | 1 | DMA interrupt level |
| irq_ide_i | input | 1 | Drive interrupt level |
| irq_dma_o | output | 1 | DMA interrupt line out |
| irq_ide_o | output | 1 | Drive interrupt line out |

## Verification
The bench targets width filtering on every register class. A design that forwards a 1-byte data write or a 2-byte task-file write would corrupt drive state that a later legal read exposes. A 1-byte data read that fails to mask would leak the upper byte. The 0x16 alias and the low address bits are exercised because a design that decodes the full address would miss the alias or map an offset access to an unmapped slot. The interrupt tests clear bit 31 while both sources are high and re-raise DMA after a clear. A design that clears the whole word, ignores the size on clear, or copies the level on every cycle would show the wrong status word.

// File: rtl/ide_regwin_pkg.sv
package ide_regwin_pkg;

   typedef enum logic [1:0] {
      SZ_B1  = 2'd0,
      SZ_B2  = 2'd1,
      SZ_B4  = 2'd2,
      SZ_BAD = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      TG_NONE,
      TG_DATA,
      TG_TASK,
      TG_CTRL,
      TG_TIMING,
      TG_ISR
   } target_e;

   typedef struct packed {
      target_e   tgt;
      logic      legal;
      logic [3:0] dreg;
      acc_size_e dsize;
   } dec_t;

   localparam int unsigned SLOT_DATA     = 0;
   localparam int unsigned SLOT_TASK_LO  = 1;
   localparam int unsigned SLOT_TASK_HI  = 7;
   localparam int unsigned SLOT_CTRL     = 8;
   localparam int unsigned SLOT_CTRL_ALT = 'h16;
   localparam int unsigned SLOT_TIMING   = 'h20;
   localparam int unsigned SLOT_ISR      = 'h30;
   localparam logic [3:0]  DREG_CTRL     = 4'd8;

endpackage

// File: rtl/ide_regwin_decode.sv
module ide_regwin_decode
   import ide_regwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned IDX_SHIFT = 4,
   parameter bit          ALIAS_EN  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              write_i,
   input  logic [1:0]        size_i,
   output dec_t              dec_o
);
   localparam int unsigned IDX_W = ADDR_W - IDX_SHIFT;
   localparam logic [IDX_W-1:0] K_DATA   = IDX_W'(SLOT_DATA);
   localparam logic [IDX_W-1:0] K_T_LO   = IDX_W'(SLOT_TASK_LO);
   localparam logic [IDX_W-1:0] K_T_HI   = IDX_W'(SLOT_TASK_HI);
   localparam logic [IDX_W-1:0] K_CTRL   = IDX_W'(SLOT_CTRL);
   localparam logic [IDX_W-1:0] K_ALT    = IDX_W'(SLOT_CTRL_ALT);
   localparam logic [IDX_W-1:0] K_TIMING = IDX_W'(SLOT_TIMING);
   localparam logic [IDX_W-1:0] K_ISR    = IDX_W'(SLOT_ISR);

   logic [IDX_W-1:0] idx;
   acc_size_e        sz;
   logic             alt_hit;
   logic             unused_low;

   assign idx        = addr_i[ADDR_W-1:IDX_SHIFT];
   assign sz         = acc_size_e'(size_i);
   assign unused_low = ^addr_i[IDX_SHIFT-1:0];

   generate
      if (ALIAS_EN) begin : g_alias
         assign alt_hit = (idx == K_ALT);
      end else begin : g_no_alias
         assign alt_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      dec_o = '{tgt: TG_NONE, legal: 1'b0, dreg: 4'd0, dsize: SZ_B1};
      if (idx == K_DATA) begin
         dec_o.tgt   = TG_DATA;
         dec_o.dsize = (sz == SZ_B1) ? SZ_B2 : sz;
         dec_o.legal = write_i ? (sz == SZ_B2 || sz == SZ_B4) : (sz != SZ_BAD);
      end else if (idx >= K_T_LO && idx <= K_T_HI) begin
         dec_o.tgt   = TG_TASK;
         dec_o.dreg  = idx[3:0];
         dec_o.legal = (sz == SZ_B1);
      end else if (idx == K_CTRL || alt_hit) begin
         dec_o.tgt   = TG_CTRL;
         dec_o.dreg  = DREG_CTRL;
         dec_o.legal = (sz == SZ_B1);
      end else if (idx == K_TIMING) begin
         dec_o.tgt   = TG_TIMING;
         dec_o.dsize = SZ_B4;
         dec_o.legal = (sz == SZ_B4);
      end else if (idx == K_ISR) begin
         dec_o.tgt   = TG_ISR;
         dec_o.dsize = SZ_B4;
         dec_o.legal = (sz == SZ_B4);
      end
   end

   // R10: an illegal size code never decodes as legal
   always_comb begin
      a_r10_bad_size_illegal: assert (!(sz == SZ_BAD && dec_o.legal));
   end

endmodule

// File: rtl/ide_regwin_irq.sv
module ide_regwin_irq #(
   parameter int unsigned N_SRC  = 2,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              clr_top_i,
   output logic [DATA_W-1:0] isr_o,
   output logic [N_SRC-1:0]  line_o
);
   generate
      if (N_SRC >= DATA_W) begin : g_bad_n
         $error("ide_regwin_irq: N_SRC must be below DATA_W");
      end

      assign isr_o[DATA_W-1-N_SRC:0] = '0;

      for (genvar n = 0; n < N_SRC; n++) begin : g_src
         logic q;
         logic st;
         logic clr;

         if (n == 0) begin : g_clr
            assign clr = clr_top_i;
         end else begin : g_noclr
            assign clr = 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q  <= 1'b0;
               st <= 1'b0;
            end else begin
               q <= src_i[n];
               if (src_i[n] != q) begin
                  st <= src_i[n];
               end else if (clr) begin
                  st <= 1'b0;
               end
            end
         end

         assign line_o[n]            = q;
         assign isr_o[DATA_W-1-n]    = st;

         // R7: a level change is captured into the status bit
         a_r7_edge_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[n] != q) |=> (isr_o[DATA_W-1-n] == $past(src_i[n])));

         // R9: the output line is the input delayed by one clock
         a_r9_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (line_o[n] == $past(src_i[n])));

         // R8: a clear without a coincident edge empties the bit
         a_r8_clear_top: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && src_i[n] == q) |=> !isr_o[DATA_W-1-n]);
      end
   endgenerate

endmodule

// File: rtl/ide_regwin_rdmux.sv
module ide_regwin_rdmux
   import ide_regwin_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  dec_t              dec_i,
   input  logic [1:0]        size_i,
   input  logic [DATA_W-1:0] drv_rdata_i,
   input  logic [DATA_W-1:0] timing_i,
   input  logic [DATA_W-1:0] isr_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   always_comb begin
      rdata_o = ALL_ONES;
      if (dec_i.legal) begin
         unique case (dec_i.tgt)
            TG_DATA: begin
               if (acc_size_e'(size_i) == SZ_B1) begin
                  rdata_o = DATA_W'(drv_rdata_i[7:0]);
               end else if (acc_size_e'(size_i) == SZ_B2) begin
                  rdata_o = DATA_W'(drv_rdata_i[15:0]);
               end else begin
                  rdata_o = drv_rdata_i;
               end
            end
            TG_TASK, TG_CTRL: rdata_o = DATA_W'(drv_rdata_i[7:0]);
            TG_TIMING:        rdata_o = timing_i;
            TG_ISR:           rdata_o = isr_i;
            default:          rdata_o = ALL_ONES;
         endcase
      end
   end

endmodule

// File: rtl/ide_regwin.sv
module ide_regwin
   import ide_regwin_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned IDX_SHIFT = 4,
   parameter bit          ALIAS_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              drv_rd,
   output logic              drv_wr,
   output logic [3:0]        drv_reg,
   output logic [1:0]        drv_size,
   output logic [DATA_W-1:0] drv_wdata,
   input  logic [DATA_W-1:0] drv_rdata,
   input  logic              irq_dma_i,
   input  logic              irq_ide_i,
   output logic              irq_dma_o,
   output logic              irq_ide_o
);
   localparam int unsigned IDX_W = ADDR_W - IDX_SHIFT;
   localparam int unsigned N_IRQ = 2;
   localparam logic [IDX_W-1:0] K_TIMING = IDX_W'(SLOT_TIMING);
   localparam logic [IDX_W-1:0] K_DATA   = IDX_W'(SLOT_DATA);

   generate
      if (DATA_W != 32) begin : g_bad_dw
         $error("ide_regwin: DATA_W must be 32");
      end
      if (IDX_SHIFT < 1 || IDX_W < 6) begin : g_bad_aw
         $error("ide_regwin: address too narrow for the register slots");
      end
   endgenerate

   dec_t              dec;
   logic              fwd;
   logic              hit_ok;
   logic [DATA_W-1:0] timing_q;
   logic [DATA_W-1:0] isr;
   logic [DATA_W-1:0] rd_next;
   logic [N_IRQ-1:0]  irq_lines;
   logic              clr_top;

   assign req_ready = 1'b1;

   ide_regwin_decode #(
      .ADDR_W(ADDR_W), .IDX_SHIFT(IDX_SHIFT), .ALIAS_EN(ALIAS_EN)
   ) u_dec (
      .addr_i(req_addr), .write_i(req_write), .size_i(req_size), .dec_o(dec)
   );

   assign hit_ok = req_valid && dec.legal;
   assign fwd    = hit_ok && (dec.tgt == TG_DATA || dec.tgt == TG_TASK || dec.tgt == TG_CTRL);

   assign drv_rd   = fwd && !req_write;
   assign drv_wr   = fwd && req_write;
   assign drv_reg  = dec.dreg;
   assign drv_size = dec.dsize;

   always_comb begin
      unique case (dec.dsize)
         SZ_B1:   drv_wdata = DATA_W'(req_wdata[7:0]);
         SZ_B2:   drv_wdata = DATA_W'(req_wdata[15:0]);
         default: drv_wdata = req_wdata;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timing_q <= '0;
      end else if (hit_ok && req_write && dec.tgt == TG_TIMING) begin
         timing_q <= req_wdata;
      end
   end

   assign clr_top = hit_ok && req_write && dec.tgt == TG_ISR && req_wdata[DATA_W-1];

   ide_regwin_irq #(.N_SRC(N_IRQ), .DATA_W(DATA_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .src_i({irq_ide_i, irq_dma_i}),
      .clr_top_i(clr_top),
      .isr_o(isr),
      .line_o(irq_lines)
   );

   assign irq_dma_o = irq_lines[0];
   assign irq_ide_o = irq_lines[1];

   ide_regwin_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .dec_i(dec), .size_i(req_size), .drv_rdata_i(drv_rdata),
      .timing_i(timing_q), .isr_i(isr), .rdata_o(rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         if (req_valid && !req_write) begin
            rsp_rdata <= rd_next;
         end
      end
   end

   // R11: every read gets a response in the next cycle
   a_r11_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   // R11: no response without a read in the cycle before
   a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid);

   // R3: a byte-wide data-port write never reaches the drive
   a_r3_byte_data_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size == 2'd0
       && req_addr[ADDR_W-1:IDX_SHIFT] == K_DATA) |-> !drv_wr);

   // R6: timing holds unless a full-word write hits it
   a_r6_timing_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_size == 2'd2
        && req_addr[ADDR_W-1:IDX_SHIFT] == K_TIMING) |=> $stable(timing_q));

   // R10: an illegal size code never touches the drive side
   a_r10_bad_size_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size == 2'd3) |-> (!drv_rd && !drv_wr));

endmodule

// File: tb/tb_ide_regwin.sv
module tb_ide_regwin;

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [1:0]  sz;
      logic [31:0] wd;
      logic [31:0] exp;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VECS [0:NV-1] = '{
      '{1'b1, 12'h000, 2'd2, 32'hA5A55A5A, 32'h0,        "R2 "},
      '{1'b0, 12'h000, 2'd2, 32'h0,        32'hA5A55A5A, "R2 "},
      '{1'b0, 12'h000, 2'd1, 32'h0,        32'h00005A5A, "R2 "},
      '{1'b0, 12'h000, 2'd0, 32'h0,        32'h0000005A, "R2 "},
      '{1'b1, 12'h000, 2'd0, 32'h00000011, 32'h0,        "R3 "},
      '{1'b0, 12'h000, 2'd2, 32'h0,        32'hA5A55A5A, "R3 "},
      '{1'b1, 12'h004, 2'd1, 32'h1234BEEF, 32'h0,        "R3 "},
      '{1'b0, 12'h008, 2'd2, 32'h0,        32'h0000BEEF, "R3 "},
      '{1'b1, 12'h035, 2'd0, 32'hABCDEFC3, 32'h0,        "R4 "},
      '{1'b0, 12'h030, 2'd0, 32'h0,        32'h000000C3, "R1 "},
      '{1'b0, 12'h030, 2'd2, 32'h0,        32'hFFFFFFFF, "R4 "},
      '{1'b1, 12'h030, 2'd1, 32'h00000077, 32'h0,        "R4 "},
      '{1'b0, 12'h03F, 2'd0, 32'h0,        32'h000000C3, "R4 "},
      '{1'b0, 12'h070, 2'd0, 32'h0,        32'h00000000, "R4 "},
      '{1'b1, 12'h080, 2'd0, 32'h0000000A, 32'h0,        "R5 "},
      '{1'b0, 12'h160, 2'd0, 32'h0,        32'h0000000A, "R5 "},
      '{1'b1, 12'h16C, 2'd0, 32'h00000002, 32'h0,        "R5 "},
      '{1'b0, 12'h080, 2'd0, 32'h0,        32'h00000002, "R5 "},
      '{1'b0, 12'h080, 2'd1, 32'h0,        32'hFFFFFFFF, "R5 "},
      '{1'b0, 12'h200, 2'd2, 32'h0,        32'h00000000, "R6 "},
      '{1'b1, 12'h200, 2'd2, 32'h12345678, 32'h0,        "R6 "},
      '{1'b0, 12'h20F, 2'd2, 32'h0,        32'h12345678, "R6 "},
      '{1'b1, 12'h200, 2'd1, 32'h0000FFFF, 32'h0,        "R6 "},
      '{1'b0, 12'h200, 2'd2, 32'h0,        32'h12345678, "R6 "},
      '{1'b0, 12'h200, 2'd0, 32'h0,        32'hFFFFFFFF, "R10"},
      '{1'b0, 12'h100, 2'd2, 32'h0,        32'hFFFFFFFF, "R10"},
      '{1'b0, 12'h3F0, 2'd2, 32'h0,        32'hFFFFFFFF, "R10"},
      '{1'b0, 12'h000, 2'd3, 32'h0,        32'hFFFFFFFF, "R10"},
      '{1'b1, 12'h000, 2'd3, 32'h00000000, 32'h0,        "R10"},
      '{1'b0, 12'h000, 2'd2, 32'h0,        32'h0000BEEF, "R10"},
      '{1'b0, 12'h300, 2'd2, 32'h0,        32'h00000000, "R7 "}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        drv_rd, drv_wr;
   logic [3:0]  drv_reg;
   logic [1:0]  drv_size;
   logic [31:0] drv_wdata;
   logic [31:0] drv_rdata;
   logic        irq_dma_i = 1'b0;
   logic        irq_ide_i = 1'b0;
   logic        irq_dma_o, irq_ide_o;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   ide_regwin dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .drv_rd(drv_rd), .drv_wr(drv_wr), .drv_reg(drv_reg), .drv_size(drv_size),
      .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
      .irq_dma_i(irq_dma_i), .irq_ide_i(irq_ide_i),
      .irq_dma_o(irq_dma_o), .irq_ide_o(irq_ide_o)
   );

   // simple drive-side register file model
   logic [31:0] drv_mem [0:8];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 9; i++) drv_mem[i] <= '0;
      end else if (drv_wr && drv_reg <= 4'd8) begin
         drv_mem[drv_reg] <= drv_wdata;
      end
   end
   assign drv_rdata = (drv_reg <= 4'd8) ? drv_mem[drv_reg] : 32'h0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] s,
                         input logic [31:0] wd, output logic rv, output logic [31:0] rd);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_size  = s;
      req_wdata = wd;
      @(negedge clk);
      rv = rsp_valid;
      rd = rsp_rdata;
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [1:0] s,
                         input logic [31:0] exp);
      logic rv;
      logic [31:0] rd;
      access(1'b0, a, s, 32'h0, rv, rd);
      chk({tag, " rsp_valid"}, {31'h0, rv}, 32'h1);
      chk(tag, rd, exp);
   endtask

   task automatic wr_do(input string tag, input logic [11:0] a, input logic [1:0] s,
                        input logic [31:0] wd);
      logic rv;
      logic [31:0] rd;
      access(1'b1, a, s, wd, rv, rd);
      chk({tag, " no rsp on write"}, {31'h0, rv}, 32'h0);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state, R9 / R11
      chk("R9 dma out in reset", {31'h0, irq_dma_o}, 32'h0);
      chk("R11 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 ready", {31'h0, req_ready}, 32'h1);
      chk("R9 ide out after reset", {31'h0, irq_ide_o}, 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) begin
            wr_do($sformatf("%s vec%0d", VECS[i].tag, i), VECS[i].addr, VECS[i].sz, VECS[i].wd);
         end else begin
            rd_chk($sformatf("%s vec%0d", VECS[i].tag, i), VECS[i].addr, VECS[i].sz, VECS[i].exp);
         end
      end

      // interrupt latch and lines
      @(negedge clk); irq_dma_i = 1'b1;
      @(negedge clk);
      chk("R9 dma out follows", {31'h0, irq_dma_o}, 32'h1);
      chk("R9 ide out stays low", {31'h0, irq_ide_o}, 32'h0);
      rd_chk("R7 dma bit", 12'h300, 2'd2, 32'h80000000);
      irq_ide_i = 1'b1;
      @(negedge clk);
      chk("R9 ide out follows", {31'h0, irq_ide_o}, 32'h1);
      rd_chk("R7 both bits", 12'h300, 2'd2, 32'hC0000000);
      wr_do("R8 clear top", 12'h300, 2'd2, 32'hFFFFFFFF);
      rd_chk("R8 only bit31 cleared", 12'h300, 2'd2, 32'h40000000);
      chk("R9 dma line unaffected by clear", {31'h0, irq_dma_o}, 32'h1);
      irq_dma_i = 1'b0;
      @(negedge clk); irq_dma_i = 1'b1;
      @(negedge clk);
      rd_chk("R7 re-rise sets bit31", 12'h300, 2'd2, 32'hC0000000);
      wr_do("R8 half-word clear", 12'h300, 2'd1, 32'h80008000);
      rd_chk("R8 half-word clear ignored", 12'h300, 2'd2, 32'hC0000000);
      wr_do("R8 bit31 zero", 12'h300, 2'd2, 32'h7FFFFFFF);
      rd_chk("R8 bit31 zero ignored", 12'h300, 2'd2, 32'hC0000000);
      irq_ide_i = 1'b0;
      @(negedge clk);
      chk("R9 ide out drops", {31'h0, irq_ide_o}, 32'h0);
      rd_chk("R7 fall clears bit30", 12'h300, 2'd2, 32'h80000000);
      irq_dma_i = 1'b0;
      @(negedge clk);
      rd_chk("R7 all clear", 12'h300, 2'd2, 32'h00000000);

      // second reset with DMA source held high
      irq_dma_i = 1'b1;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 dma out zero in reset", {31'h0, irq_dma_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 dma out after reset", {31'h0, irq_dma_o}, 32'h1);
      rd_chk("R7 level high out of reset", 12'h300, 2'd2, 32'h80000000);
      rd_chk("R6 timing reset value", 12'h200, 2'd2, 32'h00000000);

      summary();
      $finish;
   end

endmodule